// File: doc/BRIEF.md
# Aliased Status Flag Register

This block holds one 64-bit status and control word that software reaches through a small register-access port. The port carries 64-bit words only and uses word-granular offsets. A direct write loads the word. Two alias offsets next to it change the word in place, so software can set or drop flags without a read-modify-write sequence. One variant uses the first alias as an AND-merge. The other variant uses it as a clear-all. The second alias is always an OR-merge.

Bits are numbered from the most significant end: flag 0 is bit 63 of the port word. Only flags 0 through 18 exist. Every other bit reads as zero and ignores writes. Flag 0 drives a level-sensitive interrupt line. A strobe from other logic on the chip posts a message: it sets flags 0 and 3 in the same cycle, which raises the interrupt. Any access to an offset that the block does not implement produces a one-cycle indication on a separate output.

Top module: `mstat_regblk`

## Requirements
- R1: After a synchronous reset the word is zero, the interrupt is low and the unimplemented-access output is low.
- R2: Only flags 0..18, which are port bits 63..45, can hold a one. With default parameters a word of all ones stored into the register reads back as 0xFFFFE00000000000.
- R3: In the AND variant (CLEAR_ALIAS=0), a write to offset BASE_OFF+1 stores the current word ANDed with the write data.
- R4: In both variants, a write to BASE_OFF+2 stores the current word ORed with the masked write data.
- R5: In the clear variant (CLEAR_ALIAS=1), a write to BASE_OFF+1 makes the word zero whatever the write data is.
- R6: The interrupt output equals flag 0 (port bit 63) of the stored word. It changes on the same clock edge as the word and never at any other time.
- R7: A cycle with raise_msg high sets flags 0 and 3 (port bits 63 and 60) and leaves the other flags as they were.
- R8: A bus write and raise_msg in the same cycle apply the bus write first and then OR flags 0 and 3 into its result.
- R9: A write to BASE_OFF loads the masked write data. A read of BASE_OFF returns the stored word on acc_rdata in the same cycle. A read of any other offset returns zero.
- R10: An access whose acc_size is not 8 bytes is ignored. It does not change the word, it reads zero and it does not pulse unimp_flag.
- R11: An 8-byte write to an offset outside BASE_OFF..BASE_OFF+2, or an 8-byte read of any offset other than BASE_OFF, sets unimp_flag for exactly the next cycle and does not change the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | SIZE_W | Access size in bytes; only 8 is accepted |
| acc_off | input | OFF_W | Word offset of the access |
| acc_wdata | input | 64 | Write data |
| raise_msg | input | 1 | Message strobe that sets flags 0 and 3 |
| acc_rdata | output | 64 | Read data, valid in the cycle of the read |
| irq | output | 1 | Level interrupt, equal to flag 0 |
| unimp_flag | output | 1 | One-cycle pulse after an access to an unimplemented offset |

## Verification
The hardest case to reach is a raise_msg strobe in the same cycle as a bus write that would otherwise remove flag 0. Examples are an AND with zero, a clear-all, or a load of zero. In that case only the write-then-raise ordering keeps the interrupt high. The bench drives both variants with the same stimulus and places the strobe on top of every kind of alias write, including a clear-alias write with all-ones data. It also sweeps many computed data patterns over every offset near the base and over every illegal access size. Each write is followed by a readback at the base, so masking and merging are checked through the port.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int WORD_W = 64;

    typedef logic [WORD_W-1:0] word_t;

    // Update operation selected by the decoder.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_AND,
        OP_OR,
        OP_ZERO
    } op_e;

    // Decoder result for one access cycle.
    typedef struct packed {
        op_e  op;
        logic rd_hit;
        logic unimp;
    } dec_t;

    // Port bit that holds MSB-first flag number n.
    function automatic int flag_pos(input int n);
        return WORD_W - 1 - n;
    endfunction

    // Mask with the first count flags (MSB-first) set.
    function automatic word_t flag_mask(input int count);
        word_t m;
        m = '0;
        for (int i = 0; i < count; i++) begin
            m[WORD_W-1-i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mstat_decode.sv
module mstat_decode
    import mstat_pkg::*;
#(
    parameter int          OFF_W       = 16,
    parameter int unsigned BASE_OFF    = 32'h4020,
    parameter int          SIZE_W      = 4,
    parameter int          FULL_BYTES  = 8,
    parameter bit          CLEAR_ALIAS = 1'b0
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [OFF_W-1:0]  acc_off,
    output dec_t              dec
);

    localparam logic [OFF_W-1:0]  BASE_V = OFF_W'(BASE_OFF);
    localparam logic [SIZE_W-1:0] FULL_V = SIZE_W'(FULL_BYTES);

    logic             full_acc;
    logic [OFF_W-1:0] rel;
    op_e              alias1_op;

    assign full_acc = (acc_size == FULL_V);
    assign rel      = acc_off - BASE_V;

    // The variant fixes what the first alias offset does.
    generate
        if (CLEAR_ALIAS) begin : g_clear_alias
            assign alias1_op = OP_ZERO;
        end else begin : g_and_alias
            assign alias1_op = OP_AND;
        end
    endgenerate

    always_comb begin
        dec.op     = OP_IDLE;
        dec.rd_hit = 1'b0;
        dec.unimp  = 1'b0;
        if (acc_valid && full_acc) begin
            if (acc_write) begin
                if (rel == OFF_W'(0)) begin
                    dec.op = OP_LOAD;
                end else if (rel == OFF_W'(1)) begin
                    dec.op = alias1_op;
                end else if (rel == OFF_W'(2)) begin
                    dec.op = OP_OR;
                end else begin
                    dec.unimp = 1'b1;
                end
            end else begin
                if (rel == OFF_W'(0)) begin
                    dec.rd_hit = 1'b1;
                end else begin
                    dec.unimp = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mstat_merge.sv
module mstat_merge
    import mstat_pkg::*;
#(
    parameter int IMPL_BITS = 19,
    parameter int IRQ_FLAG  = 0,
    parameter int MSG_FLAG  = 3
) (
    input  word_t cur,
    input  op_e   op,
    input  word_t wdata,
    input  logic  raise_msg,
    output word_t nxt,
    output logic  upd
);

    localparam word_t KEEP    = flag_mask(IMPL_BITS);
    localparam word_t MSG_SET = (word_t'(1) << flag_pos(IRQ_FLAG))
                              | (word_t'(1) << flag_pos(MSG_FLAG));

    word_t bus_v;

    // Apply the bus operation first, then OR in the message bits, then mask.
    always_comb begin
        case (op)
            OP_LOAD: bus_v = wdata;
            OP_AND:  bus_v = cur & wdata;
            OP_OR:   bus_v = cur | wdata;
            OP_ZERO: bus_v = '0;
            default: bus_v = cur;
        endcase
        nxt = (raise_msg ? (bus_v | MSG_SET) : bus_v) & KEEP;
        upd = (op != OP_IDLE) || raise_msg;
    end

endmodule

// File: rtl/mstat_store.sv
module mstat_store
    import mstat_pkg::*;
#(
    parameter int IRQ_FLAG = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  word_t nxt,
    input  logic  rd_hit,
    input  logic  unimp_in,
    output word_t cur_q,
    output word_t rdata,
    output logic  irq,
    output logic  unimp_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            unimp_flag <= 1'b0;
        end else begin
            if (upd) begin
                cur_q <= nxt;
            end
            unimp_flag <= unimp_in;
        end
    end

    assign rdata = rd_hit ? cur_q : '0;
    assign irq   = cur_q[flag_pos(IRQ_FLAG)];

endmodule

// File: rtl/mstat_regblk.sv
module mstat_regblk
    import mstat_pkg::*;
#(
    parameter int          OFF_W       = 16,
    parameter int unsigned BASE_OFF    = 32'h4020,
    parameter int          SIZE_W      = 4,
    parameter int          FULL_BYTES  = 8,
    parameter int          IMPL_BITS   = 19,
    parameter int          IRQ_FLAG    = 0,
    parameter int          MSG_FLAG    = 3,
    parameter bit          CLEAR_ALIAS = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [63:0]       acc_wdata,
    input  logic              raise_msg,
    output logic [63:0]       acc_rdata,
    output logic              irq,
    output logic              unimp_flag
);

    dec_t  dec;
    word_t nxt;
    word_t cur_q;
    logic  upd;

    mstat_decode #(
        .OFF_W      (OFF_W),
        .BASE_OFF   (BASE_OFF),
        .SIZE_W     (SIZE_W),
        .FULL_BYTES (FULL_BYTES),
        .CLEAR_ALIAS(CLEAR_ALIAS)
    ) u_dec (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_size (acc_size),
        .acc_off  (acc_off),
        .dec      (dec)
    );

    mstat_merge #(
        .IMPL_BITS(IMPL_BITS),
        .IRQ_FLAG (IRQ_FLAG),
        .MSG_FLAG (MSG_FLAG)
    ) u_merge (
        .cur      (cur_q),
        .op       (dec.op),
        .wdata    (acc_wdata),
        .raise_msg(raise_msg),
        .nxt      (nxt),
        .upd      (upd)
    );

    mstat_store #(
        .IRQ_FLAG(IRQ_FLAG)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .nxt       (nxt),
        .rd_hit    (dec.rd_hit),
        .unimp_in  (dec.unimp),
        .cur_q     (cur_q),
        .rdata     (acc_rdata),
        .irq       (irq),
        .unimp_flag(unimp_flag)
    );

endmodule

// File: rtl/mstat_regblk_chk.sv
module mstat_regblk_chk
    import mstat_pkg::*;
#(
    parameter int          OFF_W       = 16,
    parameter int unsigned BASE_OFF    = 32'h4020,
    parameter int          SIZE_W      = 4,
    parameter int          FULL_BYTES  = 8,
    parameter int          IMPL_BITS   = 19,
    parameter int          IRQ_FLAG    = 0,
    parameter int          MSG_FLAG    = 3,
    parameter bit          CLEAR_ALIAS = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [SIZE_W-1:0] acc_size,
    input logic [OFF_W-1:0]  acc_off,
    input logic [63:0]       acc_wdata,
    input logic              raise_msg,
    input logic              irq,
    input logic              unimp_flag,
    input logic [63:0]       cur_q
);

    localparam word_t KEEP = flag_mask(IMPL_BITS);

    logic full_wr;
    assign full_wr = acc_valid && acc_write && (acc_size == SIZE_W'(FULL_BYTES));

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_q == '0 && !irq && !unimp_flag));

    a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        (cur_q & ~KEEP) == '0);

    a_r4_or_alias: assert property (@(posedge clk) disable iff (rst)
        (full_wr && acc_off == OFF_W'(BASE_OFF + 2) && !raise_msg)
        |=> cur_q == (($past(cur_q) | $past(acc_wdata)) & KEEP));

    generate
        if (CLEAR_ALIAS) begin : g_chk_clear
            a_r5_clear_alias: assert property (@(posedge clk) disable iff (rst)
                (full_wr && acc_off == OFF_W'(BASE_OFF + 1) && !raise_msg)
                |=> cur_q == '0);
        end else begin : g_chk_and
            a_r3_and_alias: assert property (@(posedge clk) disable iff (rst)
                (full_wr && acc_off == OFF_W'(BASE_OFF + 1) && !raise_msg)
                |=> cur_q == ($past(cur_q) & $past(acc_wdata)));
        end
    endgenerate

    a_r6_irq_moves_on_update: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq) |-> $past((acc_valid && acc_write) || raise_msg));

    a_r7_raise_sets: assert property (@(posedge clk) disable iff (rst)
        raise_msg |=> (irq && cur_q[flag_pos(MSG_FLAG)]));

    a_r10_partial_ignored: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_size != SIZE_W'(FULL_BYTES) && !raise_msg)
        |=> ($stable(cur_q) && !unimp_flag));

    a_r11_flag_after_access: assert property (@(posedge clk) disable iff (rst)
        unimp_flag |-> $past(acc_valid));

endmodule

bind mstat_regblk mstat_regblk_chk #(
    .OFF_W      (OFF_W),
    .BASE_OFF   (BASE_OFF),
    .SIZE_W     (SIZE_W),
    .FULL_BYTES (FULL_BYTES),
    .IMPL_BITS  (IMPL_BITS),
    .IRQ_FLAG   (IRQ_FLAG),
    .MSG_FLAG   (MSG_FLAG),
    .CLEAR_ALIAS(CLEAR_ALIAS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_off   (acc_off),
    .acc_wdata (acc_wdata),
    .raise_msg (raise_msg),
    .irq       (irq),
    .unimp_flag(unimp_flag),
    .cur_q     (cur_q)
);

// File: tb/sim_mstat_regblk.sv
module sim_mstat_regblk;

    localparam logic [15:0] BASE = 16'h4020;
    localparam logic [63:0] KEEP = 64'hFFFF_E000_0000_0000;
    localparam logic [63:0] MSG  = 64'h9000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_size = 4'd8;
    logic [15:0] acc_off = '0;
    logic [63:0] acc_wdata = '0;
    logic        raise_msg = 1'b0;

    logic [63:0] rdata_a, rdata_b;
    logic        irq_a, irq_b, unimp_a, unimp_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] ma = '0;
    logic [63:0] mb = '0;

    always #10 clk = ~clk;

    mstat_regblk #(.CLEAR_ALIAS(1'b0)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .raise_msg(raise_msg), .acc_rdata(rdata_a), .irq(irq_a), .unimp_flag(unimp_a)
    );

    mstat_regblk #(.CLEAR_ALIAS(1'b1)) u1 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .raise_msg(raise_msg), .acc_rdata(rdata_b), .irq(irq_b), .unimp_flag(unimp_b)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected next word from the requirements; clr selects the clear variant.
    function automatic logic [63:0] model(input logic [63:0] cur, input bit clr,
            input logic v, input logic w, input logic [3:0] sz, input logic [15:0] off,
            input logic [63:0] d, input logic rs);
        logic [63:0] r;
        r = cur;
        if (v && w && sz == 4'd8) begin
            if (off == BASE)             r = d & KEEP;
            else if (off == BASE + 16'd1) r = clr ? 64'd0 : (cur & d);
            else if (off == BASE + 16'd2) r = (cur | d) & KEEP;
        end
        if (rs) r = r | MSG;
        return r;
    endfunction

    task automatic step(input logic v, input logic w, input logic [3:0] sz,
                        input logic [15:0] off, input logic [63:0] d,
                        input logic rs, input string tag);
        logic [63:0] na, nb, er_a, er_b;
        logic eu;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_size = sz; acc_off = off;
        acc_wdata = d; raise_msg = rs;
        na = model(ma, 1'b0, v, w, sz, off, d, rs);
        nb = model(mb, 1'b1, v, w, sz, off, d, rs);
        eu = v && sz == 4'd8 &&
             ((w && !(off == BASE || off == BASE + 16'd1 || off == BASE + 16'd2)) ||
              (!w && off != BASE));
        #1;
        if (v && !w) begin
            er_a = (sz == 4'd8 && off == BASE) ? ma : 64'd0;
            er_b = (sz == 4'd8 && off == BASE) ? mb : 64'd0;
            check(rdata_a === er_a, tag, rdata_a, er_a);
            check(rdata_b === er_b, tag, rdata_b, er_b);
        end
        @(negedge clk);
        ma = na; mb = nb;
        check(irq_a === ma[63], "R6", {63'd0, irq_a}, {63'd0, ma[63]});
        check(irq_b === mb[63], "R6", {63'd0, irq_b}, {63'd0, mb[63]});
        check(unimp_a === eu, "R11", {63'd0, unimp_a}, {63'd0, eu});
        check(unimp_b === eu, "R11", {63'd0, unimp_b}, {63'd0, eu});
        acc_valid = 1'b0; raise_msg = 1'b0;
    endtask

    task automatic readback(input string tag);
        step(1'b1, 1'b0, 4'd8, BASE, 64'd0, 1'b0, tag);
    endtask

    function automatic logic [63:0] pat(input int i);
        logic [31:0] x;
        x = 32'(i) * 32'h9E37_79B9 + 32'h1234_5677;
        return {x, ~x ^ (32'(i) * 32'h85EB_CA6B)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        check(irq_a === 1'b0 && irq_b === 1'b0, "R1", {63'd0, irq_a | irq_b}, 64'd0);
        check(unimp_a === 1'b0 && unimp_b === 1'b0, "R1", {63'd0, unimp_a | unimp_b}, 64'd0);
        readback("R1");

        // R2: load all ones, only flags 0..18 survive
        step(1'b1, 1'b1, 4'd8, BASE, '1, 1'b0, "R9");
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_size = 4'd8; acc_off = BASE;
        #1;
        check(rdata_a === 64'hFFFF_E000_0000_0000, "R2", rdata_a, 64'hFFFF_E000_0000_0000);
        check(rdata_b === 64'hFFFF_E000_0000_0000, "R2", rdata_b, 64'hFFFF_E000_0000_0000);
        acc_valid = 1'b0;

        // Sweep: writes to every offset near the base, each followed by a readback
        for (int i = 0; i < 24; i++) begin
            for (int k = -1; k <= 3; k++) begin
                step(1'b1, 1'b1, 4'd8, BASE + 16'(k), pat(i), 1'b0,
                     (k == 1) ? "R3" : (k == 2) ? "R4" : (k == 0) ? "R9" : "R11");
                readback((k == 1) ? "R5" : "R2");
            end
        end

        // R9 / R11: reads of every nearby offset
        for (int k = -2; k <= 3; k++) begin
            step(1'b1, 1'b0, 4'd8, BASE + 16'(k), 64'd0, 1'b0, "R9");
        end

        // R10: every other access size, read and write, at the base
        step(1'b1, 1'b1, 4'd8, BASE, 64'hA5A5_0000_0000_0000, 1'b0, "R9");
        for (int s = 0; s < 16; s++) begin
            if (s != 8) begin
                step(1'b1, 1'b1, 4'(s), BASE, '1, 1'b0, "R10");
                step(1'b1, 1'b1, 4'(s), BASE + 16'd1, 64'd0, 1'b0, "R10");
                step(1'b1, 1'b0, 4'(s), BASE, 64'd0, 1'b0, "R10");
                readback("R10");
            end
        end

        // R5: clear alias with all-ones data
        step(1'b1, 1'b1, 4'd8, BASE, '1, 1'b0, "R9");
        step(1'b1, 1'b1, 4'd8, BASE + 16'd1, '1, 1'b0, "R5");
        readback("R5");
        check(mb === 64'd0 && ma === KEEP, "R5", mb, 64'd0);

        // R7: raise alone from zero and on top of existing flags
        step(1'b1, 1'b1, 4'd8, BASE, 64'd0, 1'b0, "R9");
        step(1'b0, 1'b0, 4'd8, BASE, 64'd0, 1'b1, "R7");
        readback("R7");
        check(ma === MSG, "R7", ma, MSG);
        step(1'b1, 1'b1, 4'd8, BASE, 64'h0400_0000_0000_0000, 1'b0, "R9");
        step(1'b0, 1'b0, 4'd8, BASE, 64'd0, 1'b1, "R7");
        readback("R7");

        // R8: raise together with each kind of write
        for (int k = 0; k <= 3; k++) begin
            step(1'b1, 1'b1, 4'd8, BASE, 64'h2000_0000_0000_0000, 1'b0, "R9");
            step(1'b1, 1'b1, 4'd8, BASE + 16'(k), 64'd0, 1'b1, "R8");
            readback("R8");
            step(1'b1, 1'b1, 4'd8, BASE + 16'(k), 64'h0800_0000_0000_0000, 1'b1, "R8");
            readback("R8");
        end
        step(1'b1, 1'b1, 4'd8, BASE + 16'd1, '1, 1'b1, "R8");
        readback("R8");
        check(mb === MSG, "R8", mb, MSG);

        // R6: drop flag 0 and check the interrupt falls
        step(1'b1, 1'b1, 4'd8, BASE, 64'd0, 1'b0, "R6");
        readback("R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule